// File: doc/BRIEF.md
# Round-to-Even Saturating Output Stage

This block takes a wide signed-magnitude result from a multiply-accumulate datapath and reduces it to a narrow signed-magnitude output word. The input is a sign bit plus a 16-bit magnitude with 3 integer bits and 13 fraction bits. The output is a 9-bit word made of a sign, 2 integer bits and 6 fraction bits. The seven lowest fraction bits of the magnitude are dropped. The kept magnitude is rounded to the nearest value, and an exact halfway case goes to the value whose lowest kept bit is zero.

Only the magnitude is rounded, and the sign travels alongside it unchanged. The output saturates to the largest magnitude, with the sign kept, in two cases: when the magnitude has a nonzero integer bit above the two that are kept, and when rounding carries out of the kept 8-bit magnitude. A magnitude that ends up as zero is always reported with a positive sign. With the default setting the result is registered, so it appears one clock after the input is sampled. A parameter removes the register and makes the stage purely combinational.

Top module: `rne_sat_out`

## Requirements
- R1: When magnitude bit 15 is 0 and discarded bit 6 is 0, the output magnitude `out_word[7:0]` equals input magnitude bits [14:7] (truncation).
- R2: When discarded bits [6:0] equal 7'b1000000, the kept magnitude is incremented only if its bit 0 (input bit 7) is 1. Otherwise it is left unchanged.
- R3: When discarded bit 6 is 1 and any of bits [5:0] is 1, the kept magnitude is incremented.
- R4: When input magnitude bit 15 is 1, the output magnitude is 8'hFF (11.111111).
- R5: When rounding carries out of the 8-bit kept magnitude (bits [14:6] all 1), the output magnitude is 8'hFF.
- R6: When the output magnitude is nonzero, the output sign `out_word[8]` equals the input sign, including in saturation.
- R7: When the output magnitude is zero, `out_word[8]` is 0.
- R8: With REGISTERED=1, the output reflects the input sampled at the previous rising clock edge. While `rst_n` is low, the output is 9'h000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_sign | input | 1 | Sign of the accumulator value (1 = negative) |
| acc_mag | input | 16 | Accumulator magnitude: [15:13] integer, [12:0] fraction |
| out_word | output | 9 | [8] sign, [7:6] integer, [5:0] fraction |

## Verification
Some properties are checked by assertions on every cycle: truncation when the guard bit is clear, both causes of saturation, the sign being carried through for nonzero results, the positive sign on a zero result, and the zeroed output under reset. Tie-breaking toward an even LSB and the round-up cases that come from the sticky bits are shown only by the bench. The bench sweeps every sign and magnitude combination and compares each result with an arithmetic model of rounding to nearest.

// File: rtl/rne_sat_out.sv
module rne_sat_out #(
  parameter int IN_INT     = 3,
  parameter int IN_FRAC    = 13,
  parameter int OUT_INT    = 2,
  parameter int OUT_FRAC   = 6,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acc_sign,
  input  logic [IN_INT+IN_FRAC-1:0]    acc_mag,
  output logic [OUT_INT+OUT_FRAC:0]    out_word
);
  localparam int MW   = IN_INT + IN_FRAC;
  localparam int KW   = OUT_INT + OUT_FRAC;
  localparam int DROP = IN_FRAC - OUT_FRAC;

  logic [KW-1:0] kept;
  logic          guard, sticky, rnd, big;
  logic [KW:0]   sum;
  logic [KW-1:0] mag_q;
  logic [KW:0]   res;

  assign kept   = acc_mag[DROP+KW-1:DROP];
  assign guard  = acc_mag[DROP-1];
  assign sticky = |acc_mag[DROP-2:0];
  assign big    = |acc_mag[MW-1:DROP+KW];
  assign rnd    = guard & (sticky | kept[0]);
  assign sum    = {1'b0, kept} + {{KW{1'b0}}, rnd};
  assign mag_q  = (big | sum[KW]) ? {KW{1'b1}} : sum[KW-1:0];
  assign res    = {acc_sign & (|mag_q), mag_q};

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_word <= '0;
        else        out_word <= res;
      end

      // R1
      trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!big && !acc_mag[DROP-1]) |=> out_word[KW-1:0] == $past(acc_mag[DROP+KW-1:DROP]));

      // R4
      top_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        big |=> out_word[KW-1:0] == {KW{1'b1}});

      // R5
      carry_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&acc_mag[DROP+KW-1:DROP-1]) |=> out_word[KW-1:0] == {KW{1'b1}});

      // R6
      sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|acc_mag[MW-1:DROP]) |=> out_word[KW] == $past(acc_sign));

      // R7
      zero_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_word[KW-1:0] == '0) |-> !out_word[KW]);

      // R8
      reset_clr_chk: assert property (@(posedge clk)
        !rst_n |=> out_word == '0);
    end else begin : g_comb
      assign out_word = res;
    end
  endgenerate
endmodule

// File: tb/tb_rne_sat_out.sv
module tb_rne_sat_out;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_sign = 1'b0;
  logic [15:0] acc_mag = '0;
  logic [8:0]  out_word;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  rne_sat_out dut (.clk(clk), .rst_n(rst_n), .acc_sign(acc_sign),
                   .acc_mag(acc_mag), .out_word(out_word));

  always #4 clk = ~clk;

  function automatic logic [8:0] model(input logic s, input logic [15:0] m);
    int q, r;
    q = m / 128;
    r = m % 128;
    if (r > 64 || (r == 64 && (q % 2) == 1)) q = q + 1;
    if (q > 255) q = 255;
    return {(s && q != 0), 8'(q)};
  endfunction

  function automatic string tag(input logic s, input logic [15:0] m);
    int q, r;
    q = m / 128;
    r = m % 128;
    if (m[15]) return "R4";
    if (r >= 64 && q == 255) return "R5";
    if (model(s, m)[7:0] == 8'd0) return "R7";
    if (r == 64) return "R2";
    if (r > 64) return "R3";
    if (s) return "R6";
    return "R1";
  endfunction

  task automatic check(input string req, input logic [8:0] exp);
    tests++;
    if (out_word !== exp) begin
      fails++;
      $display("FAIL %s: out_word=%h expected=%h", req, out_word, exp);
    end
  endtask

  initial begin
    logic        ps;
    logic [15:0] pm;
    // R8: reset holds output at zero even with a nonzero input
    acc_sign = 1'b1;
    acc_mag  = 16'h1234;
    repeat (3) @(negedge clk);
    check("R8", 9'h000);
    @(negedge clk);
    rst_n = 1'b1;
    // R8: one-cycle latency, value not yet updated before the edge
    acc_sign = 1'b0;
    acc_mag  = 16'h0080;
    check("R8", 9'h000);
    @(negedge clk);
    check("R8", 9'h001);
    // Directed examples: R2 tie cases and R5 carry
    acc_mag = {1'b0, 8'b0111_1111, 7'b1000000};
    @(negedge clk);
    check("R2", 9'h080);
    acc_mag = {1'b0, 8'b0100_0000, 7'b1000000};
    @(negedge clk);
    check("R2", 9'h040);
    acc_sign = 1'b1;
    acc_mag  = 16'h7FC0;
    @(negedge clk);
    check("R5", 9'h1FF);
    acc_mag  = 16'h8000;
    @(negedge clk);
    check("R4", 9'h1FF);
    acc_mag  = 16'h003F;
    @(negedge clk);
    check("R7", 9'h000);
    // Exhaustive sweep, each result checked one cycle after it is driven
    ps = 1'b0;
    pm = '0;
    for (int i = 0; i <= 131072; i++) begin
      if (i > 0) check(tag(ps, pm), model(ps, pm));
      if (i < 131072) begin
        ps = i[16];
        pm = i[15:0];
        acc_sign = ps;
        acc_mag  = pm;
        @(negedge clk);
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule